// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block is a small register file that lets a host processor hand a command to a management controller and learn how it ended. The host side is a 32-bit register bus. It has a write-only command register at byte offset 0x00 and a read-only status register at 0x04. It also has a 16-byte outbound data buffer at 0x80, which the host writes and the controller reads, and a 16-byte inbound data buffer at 0x90, which the controller fills and the host reads. Writing the command register while the block is idle latches the command word, marks the block busy and rings the controller with a one-cycle doorbell pulse. The controller reads the latched command and the outbound buffer, writes any response into the inbound buffer, and then releases busy with a one-cycle done strobe. That strobe carries an error flag and an 8-bit error code. If the command asked for it, the host gets a one-cycle completion pulse, which it never has to clear.

The sequencing is a two-state machine. The states are ST_IDLE (no command outstanding) and ST_BUSY (command handed over, waiting for the controller). There are four transitions. ACCEPT is ST_IDLE to ST_BUSY on a command write. REJECT is a command write in ST_BUSY: the machine stays in ST_BUSY and raises a sticky overrun flag. FINISH is ST_BUSY to ST_IDLE on the done strobe. STRAY_DONE is a done strobe in ST_IDLE: it is ignored and the machine stays in ST_IDLE.

Host reads return data one clock after the read request. A read selects either the whole 32-bit word or a single byte, and a byte read returns the addressed byte zero-extended.

Top module: `mbox_doorbell_top`

## Requirements
- R1: After reset, a status read returns busy 0, error 0, command id 0, initiator id equal to the INIT_ID parameter (default 0x5A) in bits 15:8, and error code 0. Every inbound buffer byte reads 0, the latched command is 0, and no doorbell or completion pulse is present.
- R2: A host write to offset 0x00 in ST_IDLE latches the full 32-bit word on c_cmd. It sets busy (status bit 0) and drives c_doorbell high for exactly the one cycle after the write.
- R3: The status word is laid out from bit 0 upward as follows: bit 0 busy, bit 1 error, bits 3:2 zero, bits 7:4 the sub-command id taken from bits 15:12 of the last accepted command, bits 15:8 the initiator id, bits 23:16 the error code, and bits 31:24 zero.
- R4: A c_done strobe in ST_BUSY clears busy and captures c_done_err into status bit 1 and c_done_code into status bits 23:16. Accepting a new command clears both fields to 0.
- R5: On FINISH, h_irq_done pulses for exactly the one cycle after the done strobe, and only if bit 8 of the accepted command word was 1. Otherwise it stays low.
- R6: A command write in ST_BUSY has no effect on c_cmd or the status fields and gives no doorbell. It sets h_overrun, which stays 1 until reset.
- R7: A c_done strobe in ST_IDLE changes no status field and gives no completion pulse.
- R8: A host write to 0x80..0x8F updates only the bytes whose h_be bit is set; bit k selects bits 8k+7:8k. The controller reads these as word c_wbuf_idx on c_wbuf_rdata. Host reads of the outbound buffer and of offset 0x00 return 0.
- R9: A c_rbuf_we write puts c_rbuf_wdata into inbound word c_rbuf_idx. Host reads present data on h_rdata one cycle after h_rd_en. With h_rd_size 1, the read returns the word at 0x90 + 4*idx. With h_rd_size 0, it returns the byte selected by h_addr[1:0] in bits 7:0, with bits 31:8 zero.
- R10: Host writes to offset 0x04 or to the inbound buffer change neither the status word nor any inbound byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr_en | input | 1 | Host write request |
| h_rd_en | input | 1 | Host read request |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables for outbound buffer writes |
| h_rd_size | input | 1 | 1 = word read, 0 = byte read |
| h_rdata | output | 32 | Host read data, one cycle after the request |
| h_irq_done | output | 1 | Completion pulse to the host |
| h_overrun | output | 1 | Sticky flag: command written while busy |
| c_doorbell | output | 1 | One-cycle pulse to the controller on ACCEPT |
| c_cmd | output | 32 | Latched command word |
| c_wbuf_idx | input | 2 | Controller word index into the outbound buffer |
| c_wbuf_rdata | output | 32 | Outbound buffer word at c_wbuf_idx |
| c_rbuf_we | input | 1 | Controller write into the inbound buffer |
| c_rbuf_idx | input | 2 | Inbound buffer word index |
| c_rbuf_wdata | input | 32 | Inbound buffer write data |
| c_done | input | 1 | Controller done strobe |
| c_done_err | input | 1 | Error flag carried with c_done |
| c_done_code | input | 8 | Error code carried with c_done |

## Verification
The hardest case to reach is the boundary between REJECT and FINISH. This is a second command write landing in the very cycle the controller strobes done, so that busy is still 1 when the write is sampled. The stimulus drives h_wr_en to offset 0x00 and c_done in the same cycle, then checks that the second command was dropped and that the completion pulse belongs to the first. A stray done strobe in ST_IDLE, sent right after a completed command, shows that the captured error fields survive.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Host map: fixed offsets, the controller firmware and host software rely on them
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_WBUF = 8'h80;
    localparam logic [7:0] OFS_RBUF = 8'h90;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } mbox_state_e;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] size;
        logic [3:0] sub;
        logic [2:0] rsvd_lo;
        logic       ioc;
        logic [7:0] code;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] err_code;
        logic [7:0] init_id;
        logic [3:0] cmd_id;
        logic [1:0] rsvd_lo;
        logic       err;
        logic       busy;
    } stat_word_t;

endpackage

// File: rtl/mbox_ctrl_fsm.sv
module mbox_ctrl_fsm
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    input  logic        done,
    input  logic        done_err,
    input  logic [7:0]  done_code,
    output logic        busy,
    output logic        err,
    output logic [7:0]  err_code,
    output logic [3:0]  sub_id,
    output logic [31:0] cmd_q,
    output logic        doorbell,
    output logic        irq_done,
    output logic        overrun
);

    mbox_state_e state, state_n;
    logic        ioc_q;
    cmd_word_t   cmd_in;

    assign cmd_in = cmd_word_t'(cmd_wdata);
    assign busy   = (state == ST_BUSY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // transitions: ACCEPT, REJECT, FINISH, STRAY_DONE
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    state_n = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (done) begin
                    state_n = ST_IDLE;
                end
            end
        endcase
    end

    // outputs and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            ioc_q    <= 1'b0;
            sub_id   <= '0;
            err      <= 1'b0;
            err_code <= '0;
            doorbell <= 1'b0;
            irq_done <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            doorbell <= 1'b0;
            irq_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_wr) begin
                        cmd_q    <= cmd_wdata;
                        ioc_q    <= cmd_in.ioc;
                        sub_id   <= cmd_in.sub;
                        err      <= 1'b0;
                        err_code <= '0;
                        doorbell <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (cmd_wr) begin
                        overrun <= 1'b1;
                    end
                    if (done) begin
                        err      <= done_err;
                        err_code <= done_code;
                        irq_done <= ioc_q;
                    end
                end
            endcase
        end
    end

    a_r2_ring_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (doorbell && busy && cmd_q == $past(cmd_wdata)));

    a_r2_doorbell_single: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    a_r6_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> (overrun && !doorbell && $stable(cmd_q) && $stable(sub_id)));

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |=> (!busy && err == $past(done_err) && err_code == $past(done_code)));

    a_r5_irq_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> ($past(done) && $past(busy)));

    a_r7_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !cmd_wr) |=> ($stable(err) && $stable(err_code) && !irq_done));

endmodule

// File: rtl/mbox_wbuf.sv
module mbox_wbuf #(
    parameter int BUF_WORDS = 4,
    localparam int IDX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [3:0]       wr_be,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [BUF_WORDS-1:0][31:0] mem;

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[w][8*b +: 8] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(w) && wr_be[b]) begin
                    mem[w][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end

    assign rd_data = mem[rd_idx];

    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));

    a_r8_masked_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[0]) |=> $stable(mem[$past(wr_idx)][7:0]));

endmodule

// File: rtl/mbox_rbuf.sv
module mbox_rbuf #(
    parameter int BUF_WORDS = 4,
    localparam int IDX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [31:0]      fill_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);

    logic [BUF_WORDS-1:0][31:0] mem;

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (fill_en && fill_idx == IDX_W'(w)) begin
                mem[w] <= fill_data;
            end
        end
    end

    assign rd_word = mem[rd_idx];

    a_r9_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (mem[$past(fill_idx)] == $past(fill_data)));

    a_r10_no_fill_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(mem));

endmodule

// File: rtl/mbox_doorbell_top.sv
module mbox_doorbell_top
    import mbox_pkg::*;
#(
    parameter int         BUF_BYTES = 16,
    parameter logic [7:0] INIT_ID   = 8'h5A,
    localparam int        BUF_WORDS = BUF_BYTES / 4,
    localparam int        IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_wr_en,
    input  logic             h_rd_en,
    input  logic [7:0]       h_addr,
    input  logic [31:0]      h_wdata,
    input  logic [3:0]       h_be,
    input  logic             h_rd_size,
    output logic [31:0]      h_rdata,
    output logic             h_irq_done,
    output logic             h_overrun,
    output logic             c_doorbell,
    output logic [31:0]      c_cmd,
    input  logic [IDX_W-1:0] c_wbuf_idx,
    output logic [31:0]      c_wbuf_rdata,
    input  logic             c_rbuf_we,
    input  logic [IDX_W-1:0] c_rbuf_idx,
    input  logic [31:0]      c_rbuf_wdata,
    input  logic             c_done,
    input  logic             c_done_err,
    input  logic [7:0]       c_done_code
);

    // address decode
    logic             hit_cmd, hit_stat, hit_wbuf, hit_rbuf;
    logic [IDX_W-1:0] wb_idx, rb_idx;

    assign hit_cmd  = (h_addr[7:2] == OFS_CMD[7:2]);
    assign hit_stat = (h_addr[7:2] == OFS_STAT[7:2]);
    assign hit_wbuf = (h_addr >= OFS_WBUF) && (32'(h_addr) < 32'(OFS_WBUF) + BUF_BYTES);
    assign hit_rbuf = (h_addr >= OFS_RBUF) && (32'(h_addr) < 32'(OFS_RBUF) + BUF_BYTES);
    assign wb_idx   = IDX_W'((h_addr - OFS_WBUF) >> 2);
    assign rb_idx   = IDX_W'((h_addr - OFS_RBUF) >> 2);

    // sequencing and status fields
    logic       busy, err;
    logic [7:0] err_code;
    logic [3:0] sub_id;

    mbox_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (h_wr_en && hit_cmd),
        .cmd_wdata (h_wdata),
        .done      (c_done),
        .done_err  (c_done_err),
        .done_code (c_done_code),
        .busy      (busy),
        .err       (err),
        .err_code  (err_code),
        .sub_id    (sub_id),
        .cmd_q     (c_cmd),
        .doorbell  (c_doorbell),
        .irq_done  (h_irq_done),
        .overrun   (h_overrun)
    );

    // outbound buffer: host writes, controller reads
    mbox_wbuf #(.BUF_WORDS(BUF_WORDS)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (h_wr_en && hit_wbuf),
        .wr_idx  (wb_idx),
        .wr_be   (h_be),
        .wr_data (h_wdata),
        .rd_idx  (c_wbuf_idx),
        .rd_data (c_wbuf_rdata)
    );

    // inbound buffer: controller writes, host reads
    logic [31:0] rbuf_word;

    mbox_rbuf #(.BUF_WORDS(BUF_WORDS)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (c_rbuf_we),
        .fill_idx  (c_rbuf_idx),
        .fill_data (c_rbuf_wdata),
        .rd_idx    (rb_idx),
        .rd_word   (rbuf_word)
    );

    // host read path
    stat_word_t  stat;
    logic [31:0] rd_word, rd_shift, rd_next;

    always_comb begin
        stat          = '0;
        stat.busy     = busy;
        stat.err      = err;
        stat.cmd_id   = sub_id;
        stat.init_id  = INIT_ID;
        stat.err_code = err_code;
    end

    always_comb begin
        if (hit_stat) begin
            rd_word = stat;
        end else if (hit_rbuf) begin
            rd_word = rbuf_word;
        end else begin
            rd_word = '0;
        end
        rd_shift = rd_word >> {h_addr[1:0], 3'b000};
        rd_next  = h_rd_size ? rd_word : {24'h0, rd_shift[7:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata <= '0;
        end else if (h_rd_en) begin
            h_rdata <= rd_next;
        end
    end

    a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && !h_rd_size) |=> (h_rdata[31:8] == 24'h0));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !h_rd_en |=> $stable(h_rdata));

    a_r3_init_id_field: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && h_rd_size && hit_stat) |=> (h_rdata[15:8] == INIT_ID && h_rdata[31:24] == 8'h0));

endmodule

// File: tb/mbox_doorbell_top_tb_top.sv
`timescale 1ns/100ps
module mbox_doorbell_top_tb_top;

    localparam logic [7:0] INIT = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr_en = 0, h_rd_en = 0, h_rd_size = 1;
    logic [7:0]  h_addr = 0;
    logic [31:0] h_wdata = 0;
    logic [3:0]  h_be = 0;
    logic [31:0] h_rdata;
    logic        h_irq_done, h_overrun, c_doorbell;
    logic [31:0] c_cmd, c_wbuf_rdata;
    logic [1:0]  c_wbuf_idx = 0, c_rbuf_idx = 0;
    logic        c_rbuf_we = 0, c_done = 0, c_done_err = 0;
    logic [31:0] c_rbuf_wdata = 0;
    logic [7:0]  c_done_code = 0;

    always #2.5 clk = ~clk;

    mbox_doorbell_top dut_i (
        .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be), .h_rd_size(h_rd_size),
        .h_rdata(h_rdata), .h_irq_done(h_irq_done), .h_overrun(h_overrun),
        .c_doorbell(c_doorbell), .c_cmd(c_cmd), .c_wbuf_idx(c_wbuf_idx),
        .c_wbuf_rdata(c_wbuf_rdata), .c_rbuf_we(c_rbuf_we), .c_rbuf_idx(c_rbuf_idx),
        .c_rbuf_wdata(c_rbuf_wdata), .c_done(c_done), .c_done_err(c_done_err),
        .c_done_code(c_done_code)
    );

    integer total = 0;
    integer bad = 0;
    bit     finished = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_busy, m_err, m_ioc, m_ovr, m_db, m_irq;
    logic [3:0]  m_sub;
    logic [7:0]  m_code;
    logic [31:0] m_cmd, m_rdata;
    logic [7:0]  m_wb [16];
    logic [7:0]  m_rb [16];

    function automatic logic [31:0] m_read(input logic [7:0] a, input logic sz);
        logic [31:0] w;
        int base;
        w = 0;
        if (a[7:2] == 6'd1) begin
            w = {8'h0, m_code, INIT, m_sub, 2'b00, m_err, m_busy};
        end else if (a >= 8'h90 && a < 8'hA0) begin
            base = int'(a - 8'h90) & ~3;
            w = {m_rb[base+3], m_rb[base+2], m_rb[base+1], m_rb[base]};
        end
        if (!sz) w = {24'h0, 8'(w >> (8 * int'(a[1:0])))};
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_ioc = 0; m_ovr = 0; m_db = 0; m_irq = 0;
            m_sub = 0; m_code = 0; m_cmd = 0; m_rdata = 0;
            for (int i = 0; i < 16; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
        end else begin
            bit was_busy;
            was_busy = m_busy;
            m_db = 0; m_irq = 0;
            if (h_rd_en) m_rdata = m_read(h_addr, h_rd_size);
            if (h_wr_en && h_addr[7:2] == 6'd0) begin
                if (was_busy) m_ovr = 1;
                else begin
                    m_busy = 1; m_cmd = h_wdata; m_sub = h_wdata[15:12];
                    m_ioc = h_wdata[8]; m_err = 0; m_code = 0; m_db = 1;
                end
            end else if (h_wr_en && h_addr >= 8'h80 && h_addr < 8'h90) begin
                for (int b = 0; b < 4; b++)
                    if (h_be[b]) m_wb[(int'(h_addr - 8'h80) & ~3) + b] = h_wdata[8*b +: 8];
            end
            if (c_done && was_busy) begin
                m_busy = 0; m_err = c_done_err; m_code = c_done_code; m_irq = m_ioc;
            end
            if (c_rbuf_we)
                for (int b = 0; b < 4; b++) m_rb[4*int'(c_rbuf_idx) + b] = c_rbuf_wdata[8*b +: 8];
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int bi;
            bi = 4 * int'(c_wbuf_idx);
            check("R2", "doorbell", 32'(c_doorbell), 32'(m_db));
            check("R2", "c_cmd", c_cmd, m_cmd);
            check("R5", "irq_done", 32'(h_irq_done), 32'(m_irq));
            check("R6", "overrun", 32'(h_overrun), 32'(m_ovr));
            check("R8", "c_wbuf_rdata", c_wbuf_rdata, {m_wb[bi+3], m_wb[bi+2], m_wb[bi+1], m_wb[bi]});
            check("R9", "h_rdata", h_rdata, m_rdata);
        end
    end

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        h_wr_en = 1; h_addr = a; h_wdata = d; h_be = be;
        @(negedge clk);
        h_wr_en = 0; h_be = 0;
    endtask

    task automatic hread(input logic [7:0] a, input logic sz, input logic [31:0] exp, input string req);
        h_rd_en = 1; h_addr = a; h_rd_size = sz;
        @(negedge clk);
        h_rd_en = 0; h_rd_size = 1;
        check(req, "host read", h_rdata, exp);
    endtask

    task automatic cdone(input logic e, input logic [7:0] code);
        c_done = 1; c_done_err = e; c_done_code = code;
        @(negedge clk);
        c_done = 0; c_done_err = 0; c_done_code = 0;
    endtask

    task automatic cfill(input logic [1:0] idx, input logic [31:0] d);
        c_rbuf_we = 1; c_rbuf_idx = idx; c_rbuf_wdata = d;
        @(negedge clk);
        c_rbuf_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset doorbell", 32'(c_doorbell), 0);
        check("R1", "reset c_cmd", c_cmd, 0);
        hread(8'h04, 1, 32'h0000_5A00, "R1");
        hread(8'h9C, 1, 32'h0, "R1");

        // R8 outbound buffer with byte enables
        hwrite(8'h80, 32'hDEAD_BEEF, 4'hF);
        hwrite(8'h84, 32'h1234_5678, 4'b0101);
        c_wbuf_idx = 2'd1;
        @(negedge clk);
        check("R8", "masked lanes", c_wbuf_rdata, 32'h0034_0078);
        c_wbuf_idx = 2'd0;
        @(negedge clk);
        check("R8", "full word", c_wbuf_rdata, 32'hDEAD_BEEF);
        hread(8'h80, 1, 32'h0, "R8");

        // R2/R3 accept with completion request, sub 3
        hwrite(8'h00, 32'h0008_31F0, 4'hF);
        check("R2", "doorbell after accept", 32'(c_doorbell), 1);
        check("R2", "latched cmd", c_cmd, 32'h0008_31F0);
        hread(8'h04, 1, 32'h0000_5A31, "R3");

        // R6 write while busy
        hwrite(8'h00, 32'h0000_2077, 4'hF);
        check("R6", "overrun set", 32'(h_overrun), 1);
        check("R6", "cmd kept", c_cmd, 32'h0008_31F0);

        // R9 fill, R4/R5 finish with error
        cfill(2'd0, 32'hA1B2_C3D4);
        cfill(2'd1, 32'h1122_3344);
        cdone(1'b1, 8'h42);
        check("R5", "irq pulse", 32'(h_irq_done), 1);
        @(negedge clk);
        check("R5", "irq single", 32'(h_irq_done), 0);
        hread(8'h04, 1, 32'h0042_5A32, "R4");
        hread(8'h90, 1, 32'hA1B2_C3D4, "R9");
        hread(8'h90, 0, 32'h0000_00D4, "R9");
        hread(8'h91, 0, 32'h0000_00C3, "R9");
        hread(8'h93, 0, 32'h0000_00A1, "R9");
        hread(8'h96, 0, 32'h0000_0022, "R9");
        hread(8'h05, 0, 32'h0000_005A, "R3");

        // R7 stray done in idle
        cdone(1'b0, 8'h99);
        check("R7", "no irq on stray", 32'(h_irq_done), 0);
        hread(8'h04, 1, 32'h0042_5A32, "R7");

        // R10 writes to read-only areas
        hwrite(8'h04, 32'hFFFF_FFFF, 4'hF);
        hwrite(8'h94, 32'hFFFF_FFFF, 4'hF);
        hread(8'h04, 1, 32'h0042_5A32, "R10");
        hread(8'h94, 1, 32'h1122_3344, "R10");

        // R5 no completion request; R4 fields cleared on accept
        hwrite(8'h00, 32'h0004_2005, 4'hF);
        hread(8'h04, 1, 32'h0000_5A21, "R4");
        // REJECT and FINISH in the same cycle
        h_wr_en = 1; h_addr = 8'h00; h_wdata = 32'h0000_F1AA; h_be = 4'hF;
        c_done = 1; c_done_err = 0; c_done_code = 8'h07;
        @(negedge clk);
        h_wr_en = 0; c_done = 0; c_done_code = 0;
        check("R5", "no irq without request", 32'(h_irq_done), 0);
        check("R6", "coincident write dropped", c_cmd, 32'h0004_2005);
        check("R6", "no doorbell", 32'(c_doorbell), 0);
        hread(8'h04, 1, 32'h0007_5A20, "R4");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule